// File: doc/BRIEF.md
# Protection Configuration Write Gate

This block keeps a bank of byte-wide protection configuration entries, one per protection region, and rules on every software write to one of them. The write is applied or dropped. The rule depends on four things: a strap that turns on the enhanced security mode, two live security control bits, the entry's current lock bit, and the value being written. The two control bits are a lock-bypass bit and a machine-lockdown bit. In lockdown, the new value itself decides the outcome. Matching against addresses, the address registers and any error reporting sit outside this block.

A write is offered by holding `wr_en` high for one cycle, with `wr_idx`, `wr_data` and the control inputs steady. The decision is combinational. An accepted value is in `cfg_flat` after that clock edge. After the same edge, a dropped write raises `wr_ignored` for exactly one cycle. The interface is a plain strobe with no back-pressure, and a write can be offered on every cycle.

Each configuration byte has this layout: read permission in bit 0, write permission in bit 1, execute permission in bit 2, address mode in bits 4:3, and the lock flag in bit 7. Entry k occupies `cfg_flat[8k+7:8k]`.

Top module: `pmpg_gate`

## Requirements
- R1: After reset, every entry reads 0 and `wr_ignored` is low.
- R2: With `epmp_en` low, a write is applied only if bit 7 (lock) of the target entry's current value is 0. Otherwise the write is dropped.
- R3: With `epmp_en` high and `rlb` high, a write to any implemented entry is applied, whatever the current lock bit, the value or `mml`.
- R4: With `epmp_en` high and both `rlb` and `mml` low, a write is applied only if the target entry's current lock bit (bit 7) is 0.
- R5: With `epmp_en` and `mml` high, a written value with bit 7 set and bit 2 (execute) clear is applied, even when the entry is currently locked.
- R6: With `epmp_en` and `mml` high and `rlb` low, a written value with bit 7 clear is applied unless its bits 2:0 equal 3'b110. A value with both bit 7 and bit 2 set is dropped. The current lock bit plays no part.
- R7: A write whose index is at or above the number of entries (16) is dropped, and it changes no entry.
- R8: A dropped write leaves every entry unchanged and raises `wr_ignored` for exactly one cycle after its clock edge. An applied write, or a cycle with no write, leaves `wr_ignored` low.
- R9: An applied write stores all eight bits of `wr_data` into the target entry only. Every other entry keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_idx | input | 5 | Target entry index |
| wr_data | input | 8 | New configuration byte |
| epmp_en | input | 1 | Strap enabling the enhanced security rules |
| rlb | input | 1 | Lock-bypass control bit |
| mml | input | 1 | Machine-lockdown control bit |
| cfg_flat | output | 128 | All entries, entry k at bits 8k+7:8k |
| wr_ignored | output | 1 | One-cycle flag for a dropped write |

## Verification
The hardest case to reach is a lockdown write to an entry that is already locked. The outcome must then follow only the shape of the new value. Getting there means first locking the entry through a legacy-mode or bypass write, and then changing `mml` without touching `rlb`. The directed sequence builds exactly that history and then walks the critical byte shapes: lock with execute, write-plus-execute without lock, and lock without execute. The random phase then mixes the control bits and indices on every write, with one in four indices out of range. By then many entries are already locked, so most of these combinations arrive on locked entries.

// File: rtl/pmpg_pkg.sv
package pmpg_pkg;
  localparam int CFG_W    = 8;
  localparam int BIT_R    = 0;
  localparam int BIT_W    = 1;
  localparam int BIT_X    = 2;
  localparam int BIT_LOCK = 7;
  localparam logic [2:0] SHARED_WX = 3'b110;

  typedef logic [CFG_W-1:0] cfg_byte_t;

  typedef enum logic [1:0] {
    POL_LEGACY,
    POL_BYPASS,
    POL_OPEN,
    POL_LOCKDOWN
  } policy_e;
endpackage

// File: rtl/pmpg_policy.sv
module pmpg_policy
  import pmpg_pkg::*;
(
  input  logic       epmp_en,
  input  logic       rlb,
  input  logic       mml,
  input  logic       cur_lock,
  input  logic       new_lock,
  input  logic [2:0] new_rwx,
  output logic       accept
);
  policy_e pol;

  always_comb begin
    if (!epmp_en)  pol = POL_LEGACY;
    else if (rlb)  pol = POL_BYPASS;
    else if (!mml) pol = POL_OPEN;
    else           pol = POL_LOCKDOWN;
  end

  always_comb begin
    unique case (pol)
      POL_LEGACY:   accept = !cur_lock;
      POL_BYPASS:   accept = 1'b1;
      POL_OPEN:     accept = !cur_lock;
      POL_LOCKDOWN: accept = (new_lock && !new_rwx[BIT_X]) ||
                             (!new_lock && (new_rwx != SHARED_WX));
      default:      accept = 1'b0;
    endcase
  end
endmodule

// File: rtl/pmpg_bank.sv
module pmpg_bank
  import pmpg_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         commit,
  input  logic [IDX_W-1:0]             wr_idx,
  input  cfg_byte_t                    wr_data,
  output logic [NUM_ENTRIES*CFG_W-1:0] cfg_flat,
  output logic                         cur_lock,
  output logic                         in_range
);
  localparam logic [IDX_W:0] NUM_EXT = (IDX_W+1)'(NUM_ENTRIES);

  cfg_byte_t entry_q [NUM_ENTRIES];

  assign in_range = ({1'b0, wr_idx} < NUM_EXT);

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
    logic hit;
    assign hit = commit && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   entry_q[g] <= '0;
      else if (hit) entry_q[g] <= wr_data;
    end
    assign cfg_flat[g*CFG_W +: CFG_W] = entry_q[g];
  end

  always_comb begin
    cur_lock = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (wr_idx == IDX_W'(i)) cur_lock = entry_q[i][BIT_LOCK];
    end
  end
endmodule

// File: rtl/pmpg_gate.sv
module pmpg_gate
  import pmpg_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [7:0]                   wr_data,
  input  logic                         epmp_en,
  input  logic                         rlb,
  input  logic                         mml,
  output logic [NUM_ENTRIES*8-1:0]     cfg_flat,
  output logic                         wr_ignored
);
  logic cur_lock;
  logic in_range;
  logic accept;
  logic commit;
  logic ign_q;

  pmpg_policy u_policy (
    .epmp_en  (epmp_en),
    .rlb      (rlb),
    .mml      (mml),
    .cur_lock (cur_lock),
    .new_lock (wr_data[BIT_LOCK]),
    .new_rwx  (wr_data[BIT_X:BIT_R]),
    .accept   (accept)
  );

  assign commit = wr_en && in_range && accept;

  pmpg_bank #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .IDX_W       (IDX_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .cfg_flat (cfg_flat),
    .cur_lock (cur_lock),
    .in_range (in_range)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ign_q <= 1'b0;
    else        ign_q <= wr_en && !commit;
  end

  assign wr_ignored = ign_q;
endmodule

// File: rtl/pmpg_gate_chk.sv
module pmpg_gate_chk #(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [IDX_W-1:0]         wr_idx,
  input logic [7:0]               wr_data,
  input logic                     epmp_en,
  input logic                     rlb,
  input logic                     mml,
  input logic [NUM_ENTRIES*8-1:0] cfg_flat,
  input logic                     wr_ignored
);
  logic       idx_ok;
  logic [7:0] cur_byte;
  logic [IDX_W-1:0] idx_q;
  logic [7:0] prev_byte;

  assign idx_ok = (int'(wr_idx) < NUM_ENTRIES);

  always_comb begin
    cur_byte  = '0;
    prev_byte = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (wr_idx == IDX_W'(i)) cur_byte  = cfg_flat[i*8 +: 8];
      if (idx_q  == IDX_W'(i)) prev_byte = cfg_flat[i*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= wr_idx;
  end

  AST_LEGACY_LOCKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && idx_ok && !epmp_en && cur_byte[7] |=> wr_ignored); // R2

  AST_BYPASS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && idx_ok && epmp_en && rlb |=> !wr_ignored); // R3

  AST_OPEN_LOCKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && idx_ok && epmp_en && !rlb && !mml && cur_byte[7] |=> wr_ignored); // R4

  AST_LOCKDOWN_LOCK_NOEXEC: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && idx_ok && epmp_en && mml && wr_data[7] && !wr_data[2] |=> !wr_ignored); // R5

  AST_LOCKDOWN_SHARED_WX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && idx_ok && epmp_en && mml && !rlb && !wr_data[7] && (wr_data[2:0] == 3'b110)
    |=> wr_ignored); // R6

  AST_RANGE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !idx_ok |=> wr_ignored); // R7

  AST_DROP_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ignored |-> cfg_flat == $past(cfg_flat)); // R8

  AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !wr_ignored); // R8

  AST_BYPASS_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && idx_ok && epmp_en && rlb |=> prev_byte == $past(wr_data)); // R9
endmodule

bind pmpg_gate pmpg_gate_chk #(
  .NUM_ENTRIES (NUM_ENTRIES),
  .IDX_W       (IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .wr_data    (wr_data),
  .epmp_en    (epmp_en),
  .rlb        (rlb),
  .mml        (mml),
  .cfg_flat   (cfg_flat),
  .wr_ignored (wr_ignored)
);

// File: tb/sim_pmpg_gate.sv
`timescale 1ns/1ps
module sim_pmpg_gate;
  localparam int N  = 16;
  localparam int IW = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [IW-1:0]  wr_idx = '0;
  logic [7:0]     wr_data = '0;
  logic           epmp_en = 1'b0;
  logic           rlb = 1'b0;
  logic           mml = 1'b0;
  logic [N*8-1:0] cfg_flat;
  logic           wr_ignored;

  int n_checks = 0;
  int n_fails  = 0;
  logic [7:0] model [N];

  always #5 clk = ~clk;

  pmpg_gate #(.NUM_ENTRIES(N), .IDX_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .epmp_en(epmp_en), .rlb(rlb), .mml(mml), .cfg_flat(cfg_flat), .wr_ignored(wr_ignored)
  );

  function automatic bit model_accept(int idx, logic [7:0] v, bit ep, bit rl, bit ml);
    logic [7:0] cur;
    if (idx >= N) return 1'b0;
    cur = model[idx];
    if (!ep) return !cur[7];
    if (rl) return 1'b1;
    if (!ml) return !cur[7];
    if (v[7] && !v[2]) return 1'b1;
    if (!v[7] && v[2:0] != 3'b110) return 1'b1;
    return 1'b0;
  endfunction

  function automatic string rule_tag(int idx, logic [7:0] v, bit ep, bit rl, bit ml);
    if (idx >= N) return "R7";
    if (!ep) return "R2";
    if (rl) return "R3";
    if (!ml) return "R4";
    if (v[7] && !v[2]) return "R5";
    return "R6";
  endfunction

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_array(string req);
    logic [N*8-1:0] e;
    for (int i = 0; i < N; i++) e[i*8 +: 8] = model[i];
    chk(cfg_flat == e, req, "entries", cfg_flat, e);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  // Drives one write at a falling edge and checks the result at the next falling edge.
  task automatic do_write(int idx, logic [7:0] v, bit ep, bit rl, bit ml);
    bit    acc;
    string tag;
    acc = model_accept(idx, v, ep, rl, ml);
    tag = rule_tag(idx, v, ep, rl, ml);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_data = v;
    epmp_en = ep; rlb = rl; mml = ml;
    @(negedge clk);
    wr_en = 1'b0;
    if (acc) model[idx] = v;
    chk(wr_ignored == !acc, tag, "wr_ignored", 128'(wr_ignored), 128'(!acc));
    chk_array(acc ? "R9" : "R8");
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_array("R1");
    chk(wr_ignored == 1'b0, "R1", "wr_ignored after reset", 128'(wr_ignored), 128'(0));

    // Legacy rules: R2
    do_write(3, 8'h1F, 0, 0, 0);
    do_write(3, 8'h9F, 0, 0, 0);
    do_write(3, 8'h00, 0, 0, 0);
    do_write(3, 8'h01, 0, 1, 1);  // rlb/mml ignored without the strap (R2)
    // Bypass: R3
    do_write(3, 8'h05, 1, 1, 1);
    do_write(3, 8'h81, 0, 0, 0);
    do_write(3, 8'h8C, 1, 1, 0);
    // Enhanced, lockdown clear: R4
    do_write(3, 8'h07, 1, 0, 0);
    do_write(4, 8'h0F, 1, 0, 0);
    // Lockdown on a locked entry: R5, R6
    do_write(3, 8'h81, 1, 0, 1);
    do_write(3, 8'h84, 1, 0, 1);
    do_write(3, 8'h06, 1, 0, 1);
    do_write(3, 8'h0E, 1, 0, 1);
    do_write(3, 8'h07, 1, 0, 1);
    do_write(3, 8'h83, 1, 0, 1);
    do_write(3, 8'h02, 1, 0, 1);
    // Out of range: R7
    do_write(16, 8'h11, 1, 1, 0);
    do_write(31, 8'h22, 0, 0, 0);
    // Idle cycle: no flag (R8)
    @(negedge clk);
    chk(wr_ignored == 1'b0, "R8", "idle wr_ignored", 128'(wr_ignored), 128'(0));

    for (int k = 0; k < 600; k++) begin
      int         idx;
      logic [7:0] v;
      idx = (($urandom % 4) == 0) ? int'(N + ($urandom % (32 - N))) : int'($urandom % N);
      v   = 8'($urandom);
      do_write(idx, v, 1'($urandom), (($urandom % 5) == 0), 1'($urandom));
      if (($urandom % 8) == 0) begin
        @(negedge clk);
        chk(wr_ignored == 1'b0, "R8", "pulse width", 128'(wr_ignored), 128'(0));
        chk_array("R8");
      end
    end
    finish_run();
  end
endmodule